// File: doc/BRIEF.md
# DMA Channel Link Trigger Controller

This block sits beside one channel of a four-channel DMA engine and decides when that channel hands work on to another channel. Each time the channel finishes a transfer it reports a done pulse and whether its byte count has reached zero. The block compares these with the programmed link condition and the cycle-steal mode. When they match, it sends a one-cycle request to the selected target channel. One condition passes work to two targets in turn: the first target after every cycle-steal transfer, and the second target once the count reaches zero.

Before an access begins, the block checks the channel's configuration. A channel that names itself as a link target, or a source or destination size that does not fit the low bits of its address, raises a sticky configuration error. When that happens, the pending start is dropped and no access is issued. The error can raise an interrupt, and software clears it with a write-one-to-clear input. When any linking is enabled, the block forces the bandwidth-control value it passes to the arbiter to zero, so that throttling cannot let another channel in while a chain is in progress.

Top module: `dma_link_ctrl`

## Requirements
- R1: With link condition 00, a transfer-done pulse never produces a link request.
- R2: With link condition 10, a done pulse requests target one when cycle-steal mode is on, and requests nothing when it is off.
- R3: With link condition 11, a done pulse requests target one only when the byte-count-zero flag is set.
- R4: With link condition 01, a done pulse with the count not zero requests target one only in cycle-steal mode. A done pulse with the count zero requests target two, never target one, in either mode.
- R5: A target number 0 to 3 (binary) selects the matching bit of `link_req`. The request is high for exactly the one cycle after the done pulse, and at most one bit is ever set.
- R6: One cycle after its inputs, `bwc_eff` is zero whenever the link condition is nonzero, and equals `bwc_cfg` otherwise.
- R7: A start attempt with a nonzero link condition and either target number equal to `own_ch` sets `cfg_err` and issues no `access_go`.
- R8: Size codes are 00 byte, 01 16-bit, 10 32-bit and 11 16-byte line. A 16-bit size with address bit 0 set, a 32-bit size with either of address bits 1:0 set, or a line size with any of address bits 3:0 set, on source or destination, sets `cfg_err` at the start attempt and issues no `access_go`. A byte size never errors.
- R9: The start input sets `start_pend` on the next edge. On the edge after that, a clean configuration gives a one-cycle `access_go` and a bad one sets `cfg_err`. Either way, `start_pend` clears on that same edge.
- R10: `cfg_err` stays set until `err_clr` is pulsed. While it is set, no link request and no `access_go` is produced.
- R11: `err_irq` equals `cfg_err` ANDed with `err_irq_en`, registered on the same edge as the error.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_ch | input | 2 | Index of this channel |
| link_cond | input | 2 | Link condition code |
| link_tgt1 | input | 2 | First link target channel |
| link_tgt2 | input | 2 | Second link target channel |
| steal_mode | input | 1 | Cycle-steal mode enable |
| bwc_cfg | input | 3 | Programmed bandwidth-control value |
| err_irq_en | input | 1 | Interrupt enable for configuration errors |
| start_set | input | 1 | Software start strobe |
| src_size | input | 2 | Source access size code |
| dst_size | input | 2 | Destination access size code |
| src_addr_lo | input | 4 | Low source address bits |
| dst_addr_lo | input | 4 | Low destination address bits |
| xfer_done | input | 1 | Transfer-complete pulse |
| bcr_zero | input | 1 | Byte count has reached zero |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| link_req | output | 4 | One-hot link request pulse |
| bwc_eff | output | 3 | Effective bandwidth-control value |
| start_pend | output | 1 | Start is pending |
| access_go | output | 1 | Access begins (one-cycle pulse) |
| cfg_err | output | 1 | Sticky configuration error |
| err_irq | output | 1 | Configuration-error interrupt |

## Verification
Random link trials go through every combination of condition code, cycle-steal mode and count-zero flag, with random target numbers on every channel. This shows whether each code picks the right target, picks none, or wrongly picks target one at the final count. Random start trials use random sizes and low address bits. This separates each size's alignment rule from the others and from the self-link check, which is mixed in by sometimes making a target equal the channel's own index. Directed cases cover the final chained transfer with steal mode off, an interrupt that is disabled, and link pulses sent while the error is latched. These show that the error blocks linking and that it clears only on the clear strobe.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;
  typedef enum logic [1:0] {
    LC_NONE  = 2'b00,
    LC_CHAIN = 2'b01,
    LC_STEAL = 2'b10,
    LC_ZERO  = 2'b11
  } link_cond_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/dma_link_cfg_check.sv
module dma_link_cfg_check import dma_link_pkg::*; #(
  parameter int NCH        = 4,
  parameter int LINE_BYTES = 16,
  localparam int CH_W      = $clog2(NCH),
  localparam int ALIGN_W   = $clog2(LINE_BYTES)
) (
  input  logic [CH_W-1:0]    own_ch,
  input  logic [1:0]         link_cond,
  input  logic [CH_W-1:0]    link_tgt1,
  input  logic [CH_W-1:0]    link_tgt2,
  input  logic [1:0]         src_size,
  input  logic [1:0]         dst_size,
  input  logic [ALIGN_W-1:0] src_addr_lo,
  input  logic [ALIGN_W-1:0] dst_addr_lo,
  output logic               self_err,
  output logic               align_err
);
  localparam int NEP = 2;

  logic [NEP-1:0][1:0]         size_a;
  logic [NEP-1:0][ALIGN_W-1:0] addr_a;
  logic [NEP-1:0]              mis;

  assign size_a[0] = src_size;
  assign size_a[1] = dst_size;
  assign addr_a[0] = src_addr_lo;
  assign addr_a[1] = dst_addr_lo;

  // Per-endpoint alignment test
  for (genvar e = 0; e < NEP; e++) begin : g_ep
    always_comb begin
      unique case (xfer_size_e'(size_a[e]))
        SZ_BYTE: mis[e] = 1'b0;
        SZ_HALF: mis[e] = addr_a[e][0];
        SZ_WORD: mis[e] = |addr_a[e][1:0];
        default: mis[e] = |addr_a[e];
      endcase
    end
  end

  assign align_err = |mis;
  assign self_err  = (link_cond != LC_NONE) &&
                     ((link_tgt1 == own_ch) || (link_tgt2 == own_ch));
endmodule

// File: rtl/dma_link_trigger.sv
module dma_link_trigger import dma_link_pkg::*; #(
  parameter int NCH   = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            fire,
  input  logic [1:0]      link_cond,
  input  logic            steal_mode,
  input  logic            bcr_zero,
  input  logic [CH_W-1:0] link_tgt1,
  input  logic [CH_W-1:0] link_tgt2,
  output logic [NCH-1:0]  req_vec
);
  logic use_t1, use_t2;

  always_comb begin
    use_t1 = 1'b0;
    use_t2 = 1'b0;
    if (fire) begin
      unique case (link_cond_e'(link_cond))
        LC_NONE:  ;
        LC_STEAL: use_t1 = steal_mode;
        LC_ZERO:  use_t1 = bcr_zero;
        default: begin
          use_t2 = bcr_zero;
          use_t1 = steal_mode && !bcr_zero;
        end
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign req_vec[c] = (use_t1 && (link_tgt1 == CH_W'(c))) ||
                        (use_t2 && (link_tgt2 == CH_W'(c)));
  end
endmodule

// File: rtl/dma_link_ctrl.sv
module dma_link_ctrl import dma_link_pkg::*; #(
  parameter int NCH        = 4,
  parameter int BWC_W      = 3,
  parameter int LINE_BYTES = 16,
  localparam int CH_W      = $clog2(NCH),
  localparam int ALIGN_W   = $clog2(LINE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CH_W-1:0]    own_ch,
  input  logic [1:0]         link_cond,
  input  logic [CH_W-1:0]    link_tgt1,
  input  logic [CH_W-1:0]    link_tgt2,
  input  logic               steal_mode,
  input  logic [BWC_W-1:0]   bwc_cfg,
  input  logic               err_irq_en,
  input  logic               start_set,
  input  logic [1:0]         src_size,
  input  logic [1:0]         dst_size,
  input  logic [ALIGN_W-1:0] src_addr_lo,
  input  logic [ALIGN_W-1:0] dst_addr_lo,
  input  logic               xfer_done,
  input  logic               bcr_zero,
  input  logic               err_clr,
  output logic [NCH-1:0]     link_req,
  output logic [BWC_W-1:0]   bwc_eff,
  output logic               start_pend,
  output logic               access_go,
  output logic               cfg_err,
  output logic               err_irq
);
  logic self_err, align_err;
  logic [NCH-1:0] req_next;
  logic attempt, new_err, go_next, err_next;

  dma_link_cfg_check #(.NCH(NCH), .LINE_BYTES(LINE_BYTES)) u_check (
    .own_ch      (own_ch),
    .link_cond   (link_cond),
    .link_tgt1   (link_tgt1),
    .link_tgt2   (link_tgt2),
    .src_size    (src_size),
    .dst_size    (dst_size),
    .src_addr_lo (src_addr_lo),
    .dst_addr_lo (dst_addr_lo),
    .self_err    (self_err),
    .align_err   (align_err)
  );

  dma_link_trigger #(.NCH(NCH)) u_trig (
    .fire       (xfer_done && !cfg_err),
    .link_cond  (link_cond),
    .steal_mode (steal_mode),
    .bcr_zero   (bcr_zero),
    .link_tgt1  (link_tgt1),
    .link_tgt2  (link_tgt2),
    .req_vec    (req_next)
  );

  // Start check happens while a start is pending and no error is latched
  assign attempt  = start_pend && !cfg_err;
  assign new_err  = attempt && (self_err || align_err);
  assign go_next  = attempt && !self_err && !align_err;
  assign err_next = (cfg_err && !err_clr) || new_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_req   <= '0;
      bwc_eff    <= '0;
      start_pend <= 1'b0;
      access_go  <= 1'b0;
      cfg_err    <= 1'b0;
      err_irq    <= 1'b0;
    end else begin
      link_req   <= req_next;
      bwc_eff    <= (link_cond != LC_NONE) ? '0 : bwc_cfg;
      start_pend <= (go_next || new_err) ? 1'b0 : (start_pend || start_set);
      access_go  <= go_next;
      cfg_err    <= err_next;
      err_irq    <= err_next && err_irq_en;
    end
  end

  assert_onehot_link_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_req));
  assert_link_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (link_req != '0) |=> (link_req == '0) || $past(xfer_done));
  assert_bwc_forced_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(link_cond) != 2'b00) |-> (bwc_eff == '0));
  assert_go_clears_start_R9: assert property (@(posedge clk) disable iff (rst)
    access_go |-> !start_pend);
  assert_go_single_R9: assert property (@(posedge clk) disable iff (rst)
    access_go |=> !access_go);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !err_clr) |=> cfg_err);
  assert_err_blocks_link_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> (link_req == '0));
  assert_no_go_with_err_R10: assert property (@(posedge clk) disable iff (rst)
    access_go |-> !cfg_err);
  assert_irq_needs_err_R11: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> cfg_err);
endmodule

// File: tb/test_dma_link_ctrl.sv
module test_dma_link_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] own_ch, link_cond, link_tgt1, link_tgt2;
  logic steal_mode, err_irq_en, start_set, xfer_done, bcr_zero, err_clr;
  logic [2:0] bwc_cfg;
  logic [1:0] src_size, dst_size;
  logic [3:0] src_addr_lo, dst_addr_lo;
  logic [3:0] link_req;
  logic [2:0] bwc_eff;
  logic start_pend, access_go, cfg_err, err_irq;

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  dma_link_ctrl i_dma_link_ctrl (
    .clk(clk), .rst(rst), .own_ch(own_ch), .link_cond(link_cond),
    .link_tgt1(link_tgt1), .link_tgt2(link_tgt2), .steal_mode(steal_mode),
    .bwc_cfg(bwc_cfg), .err_irq_en(err_irq_en), .start_set(start_set),
    .src_size(src_size), .dst_size(dst_size), .src_addr_lo(src_addr_lo),
    .dst_addr_lo(dst_addr_lo), .xfer_done(xfer_done), .bcr_zero(bcr_zero),
    .err_clr(err_clr), .link_req(link_req), .bwc_eff(bwc_eff),
    .start_pend(start_pend), .access_go(access_go), .cfg_err(cfg_err),
    .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_link(input logic [1:0] c, input logic s,
      input logic z, input logic [1:0] t1, input logic [1:0] t2);
    logic [3:0] v = '0;
    case (c)
      2'b10: if (s) v[t1] = 1'b1;
      2'b11: if (z) v[t1] = 1'b1;
      2'b01: begin
        if (z) v[t2] = 1'b1;
        else if (s) v[t1] = 1'b1;
      end
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic mis(input logic [1:0] sz, input logic [3:0] a);
    case (sz)
      2'b01:   return a[0];
      2'b10:   return a[1:0] != 2'b00;
      2'b11:   return a != 4'h0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string link_tag(input logic [1:0] c);
    case (c)
      2'b00: return "R1";
      2'b10: return "R2";
      2'b11: return "R3";
      default: return "R4";
    endcase
  endfunction

  // One link trial: R1..R6
  task automatic link_trial(input logic [1:0] c, input logic s, input logic z,
      input logic [1:0] own, input logic [1:0] t1, input logic [1:0] t2, input logic [2:0] bw);
    @(negedge clk);
    link_cond = c; steal_mode = s; bcr_zero = z; own_ch = own;
    link_tgt1 = t1; link_tgt2 = t2; bwc_cfg = bw; xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(link_tag(c), 32'(link_req), 32'(exp_link(c, s, z, t1, t2)));
    chk("R6", 32'(bwc_eff), (c != 2'b00) ? 32'd0 : 32'(bw));
    @(negedge clk);
    chk("R5", 32'(link_req), 32'd0);
  endtask

  // One start trial: R7..R11
  task automatic start_trial(input logic [1:0] c, input logic [1:0] own,
      input logic [1:0] t1, input logic [1:0] t2, input logic [1:0] ss,
      input logic [1:0] ds, input logic [3:0] sa, input logic [3:0] da, input logic ie);
    logic selfe, alie, bad;
    string tag;
    selfe = (c != 2'b00) && (t1 == own || t2 == own);
    alie  = mis(ss, sa) || mis(ds, da);
    bad   = selfe || alie;
    tag   = selfe ? "R7" : (alie ? "R8" : "R9");
    @(negedge clk);
    link_cond = c; own_ch = own; link_tgt1 = t1; link_tgt2 = t2;
    src_size = ss; dst_size = ds; src_addr_lo = sa; dst_addr_lo = da;
    err_irq_en = ie; start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    chk("R9", 32'(start_pend), 32'd1);
    chk("R9", 32'(access_go), 32'd0);
    @(negedge clk);
    chk(tag, 32'(access_go), 32'(!bad));
    chk(tag, 32'(cfg_err), 32'(bad));
    chk("R11", 32'(err_irq), 32'(bad && ie));
    chk("R9", 32'(start_pend), 32'd0);
    @(negedge clk);
    chk("R9", 32'(access_go), 32'd0);
    chk("R10", 32'(cfg_err), 32'(bad));
    if (bad) begin
      link_cond = 2'b11; bcr_zero = 1'b1; steal_mode = 1'b1; xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk("R10", 32'(link_req), 32'd0);
      chk("R10", 32'(cfg_err), 32'd1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R10", 32'(cfg_err), 32'd0);
      chk("R11", 32'(err_irq), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    own_ch = 2'd0; link_cond = 2'b00; link_tgt1 = 2'd1; link_tgt2 = 2'd2;
    steal_mode = 1'b0; err_irq_en = 1'b0; start_set = 1'b0; xfer_done = 1'b0;
    bcr_zero = 1'b0; err_clr = 1'b0; bwc_cfg = 3'd5;
    src_size = 2'b00; dst_size = 2'b00; src_addr_lo = 4'h0; dst_addr_lo = 4'h0;
    repeat (3) @(negedge clk);
    chk("R12", 32'(link_req), 32'd0);
    chk("R12", 32'(bwc_eff), 32'd0);
    chk("R12", 32'({start_pend, access_go, cfg_err, err_irq}), 32'd0);
    rst = 1'b0;

    // Directed corners
    link_trial(2'b01, 1'b0, 1'b1, 2'd0, 2'd1, 2'd3, 3'd6);  // R4 final without steal
    link_trial(2'b01, 1'b1, 1'b1, 2'd0, 2'd1, 2'd3, 3'd6);  // R4 final with steal
    link_trial(2'b01, 1'b0, 1'b0, 2'd0, 2'd1, 2'd3, 3'd6);  // R4 no steal, nothing
    link_trial(2'b10, 1'b0, 1'b1, 2'd1, 2'd2, 2'd3, 3'd2);  // R2 steal off
    link_trial(2'b00, 1'b1, 1'b1, 2'd1, 2'd2, 2'd3, 3'd7);  // R1 with bwc passthrough
    start_trial(2'b01, 2'd2, 2'd2, 2'd0, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1); // R7
    start_trial(2'b00, 2'd2, 2'd2, 2'd2, 2'b00, 2'b00, 4'h0, 4'h0, 1'b1); // R7 unlinked is fine
    start_trial(2'b00, 2'd1, 2'd0, 2'd0, 2'b11, 2'b00, 4'h8, 4'h0, 1'b0); // R8 line, irq off
    start_trial(2'b00, 2'd1, 2'd0, 2'd0, 2'b00, 2'b10, 4'hF, 4'h4, 1'b1); // R8 byte ok, word ok

    for (int i = 0; i < 300; i++) begin
      link_trial(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 3'($urandom));
    end
    for (int i = 0; i < 200; i++) begin
      logic [1:0] own = 2'($urandom);
      logic [1:0] t1 = 2'($urandom);
      logic [1:0] t2 = 2'($urandom);
      if (($urandom % 4) != 0) begin
        if (t1 == own) t1 = own + 2'd1;
        if (t2 == own) t2 = own + 2'd2;
      end
      start_trial(2'($urandom), own, t1, t2, 2'($urandom), 2'($urandom),
                  4'($urandom), 4'($urandom), 1'($urandom));
    end

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule